// File: doc/BRIEF.md
# Expression Stack Top Cache with Migration Export

This block keeps the topmost words of a processor's expression stack in registers and backs the deeper words with a region of word-addressed stack memory. Commands take no operand addresses; they act on the top of the stack. A push puts a word on top, a pop drops the top word, and an add replaces the two top words with their sum. When the register window is full, a push first writes the deepest cached word out to memory. When a pop or add finds too few cached words, the missing word is first read back from memory. These transfers use a simple request/acknowledge port and need no help from software.

For moving a thread to another core, an export command takes a depth. The block writes every cached word below that depth back to stack memory, or refills from memory until that many words are cached. It then streams exactly that many words out, top first, with a valid/ready/last handshake. The cache is empty when the export ends. On the receiving core, an import command rebuilds the cache from a stream in the same order.

Stack memory lives only on the thread's home core. While the `at_home` input is low, any needed spill or fill raises a return-home flag instead of touching memory. The command then waits until the thread is back home.

Top module: `stk_cache_top`

## Requirements
- R1: After reset the cache holds no words, `cmd_ready`, `mem_req`, `xo_valid`, `xi_ready` and `ret_home` are low, and the memory stack pointer equals `SP_BASE`.
- R2: Command codes on `cmd_op`: 0 push, 1 pop, 2 add, 3 export, 4 import. A push places `cmd_data` on top and raises the count by one. A pop removes the top word. An add replaces the two top words with their sum modulo 2^WIDTH and lowers the count by one.
- R3: A push to a full cache first writes the deepest cached word to address stack-pointer minus one, decrements the stack pointer, and then completes the push, leaving the count at DEPTH.
- R4: A pop with no cached word, or an add with fewer than two, first reads the word at the stack pointer into the slot just below the deepest cached word and increments the stack pointer. It then completes the command.
- R5: `cmd_ready` is high only in the cycle a command completes. While a memory access is outstanding it is low, and `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold until `mem_ack`.
- R6: On export, cached words below the requested depth are written back deepest first, each at the next lower address, before any export word is offered.
- R7: On export with fewer cached words than the requested depth, words are read back from memory until the count equals the depth.
- R8: Export streams the cached words top first and marks the final word with `xo_last`. The cache is empty afterwards. A depth of 0 counts as 1, and a depth above DEPTH counts as DEPTH.
- R9: Import first empties the cache. Each accepted word goes below the previous one, so the first word becomes the top. Words beyond DEPTH are accepted and dropped, and the command completes on the word marked `xi_last`.
- R10: While `at_home` is low, a command that needs a spill or fill raises `ret_home`, issues no memory request and does not complete. Once `at_home` is high, `ret_home` clears and the command proceeds.
- R11: Command codes 5 to 7 complete in the cycle they are presented and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; held until `cmd_ready` |
| cmd_op | input | 3 | Command code |
| cmd_data | input | WIDTH | Word to push |
| cmd_depth | input | $clog2(DEPTH+1) | Number of words to export |
| cmd_ready | output | 1 | Command completes this cycle |
| tos_data | output | WIDTH | Current top word |
| tos_count | output | $clog2(DEPTH+1) | Number of cached words |
| at_home | input | 1 | Thread runs on the core holding its stack memory |
| ret_home | output | 1 | Spill or fill needed while away from home |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | WIDTH | Write word |
| mem_ack | input | 1 | Request finished; read word valid |
| mem_rdata | input | WIDTH | Read word |
| xo_valid | output | 1 | Export word valid |
| xo_ready | input | 1 | Export word taken |
| xo_data | output | WIDTH | Export word |
| xo_last | output | 1 | Final export word |
| xi_valid | input | 1 | Import word valid |
| xi_ready | output | 1 | Import word taken |
| xi_data | input | WIDTH | Import word |
| xi_last | input | 1 | Final import word |

## Verification
The bench builds the block with DEPTH=4, WIDTH=16, AW=8 and SP_BASE=0x40. With only four slots, overflow is reached within a few pushes, and a double spill followed by two fills is easy to drive. The 3-bit depth field can carry values 5 to 7, which exercises depth clamping. With 16-bit words, adding to 0xFFFF shows the wrap. The bench memory is preloaded with address-tagged words, so every fill shows which address it read.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
    localparam logic [2:0] OP_PUSH   = 3'd0;
    localparam logic [2:0] OP_POP    = 3'd1;
    localparam logic [2:0] OP_ADD    = 3'd2;
    localparam logic [2:0] OP_EXPORT = 3'd3;
    localparam logic [2:0] OP_IMPORT = 3'd4;

    typedef enum logic [2:0] {
        SO_NONE,
        SO_PUSH,
        SO_POP,
        SO_BIN,
        SO_WR
    } slot_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM,
        ST_XADJ,
        ST_XOUT,
        ST_XIN
    } ctl_state_t;
endpackage

// File: rtl/stk_store.sv
`timescale 1ns/1ps
module stk_store
    import stk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slot_op_t         op,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDXW-1:0]  widx,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [WIDTH-1:0] top0,
    output logic [WIDTH-1:0] top1,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [WIDTH-1:0] slot_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] upper;
        logic [WIDTH-1:0] lower;
        logic [WIDTH-1:0] nxt;

        if (i == 0) begin : g_top
            assign upper = wdata;
        end else begin : g_inner
            assign upper = slot_q[i-1];
        end

        if (i == DEPTH - 1) begin : g_floor
            assign lower = '0;
        end else begin : g_above_floor
            assign lower = slot_q[i+1];
        end

        always_comb begin
            nxt = slot_q[i];
            unique case (op)
                SO_PUSH: nxt = upper;
                SO_POP:  nxt = lower;
                SO_BIN:  nxt = (i == 0) ? wdata : lower;
                SO_WR:   if (widx == IDXW'(i)) nxt = wdata;
                default: ;
            endcase
        end

        assign slot_d[i] = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= slot_d[k];
        end
    end

    assign top0    = slot_q[0];
    assign top1    = slot_q[1];
    assign rd_data = slot_q[rd_idx];

    // R2: a push shows the pushed word on top one cycle later
    a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SO_PUSH) |=> (top0 == $past(wdata)));

    // R2: a pop moves the second word up to the top
    a_r2_pop_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SO_POP) |=> (top0 == $past(top1)));
endmodule

// File: rtl/stk_memport.sv
`timescale 1ns/1ps
module stk_memport #(
    parameter int AW    = 16,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_we,
    input  logic [AW-1:0]    start_addr,
    input  logic [WIDTH-1:0] start_wdata,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    input  logic             mem_ack
);
    typedef struct packed {
        logic             req;
        logic             we;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] wdata;
    } port_t;

    port_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (p_q.req && mem_ack) begin
            p_d.req = 1'b0;
        end else if (!p_q.req && start) begin
            p_d.req   = 1'b1;
            p_d.we    = start_we;
            p_d.addr  = start_addr;
            p_d.wdata = start_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign done      = p_q.req && mem_ack;
    assign mem_req   = p_q.req;
    assign mem_we    = p_q.we;
    assign mem_addr  = p_q.addr;
    assign mem_wdata = p_q.wdata;

    // R5: an unanswered request keeps its address, direction and data
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
endmodule

// File: rtl/stk_cache_top.sv
`timescale 1ns/1ps
module stk_cache_top
    import stk_pkg::*;
#(
    parameter int            DEPTH   = 8,
    parameter int            WIDTH   = 32,
    parameter int            AW      = 16,
    parameter logic [AW-1:0] SP_BASE = 16'h0100,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_data,
    input  logic [CW-1:0]    cmd_depth,
    output logic             cmd_ready,
    output logic [WIDTH-1:0] tos_data,
    output logic [CW-1:0]    tos_count,
    input  logic             at_home,
    output logic             ret_home,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic             xo_valid,
    input  logic             xo_ready,
    output logic [WIDTH-1:0] xo_data,
    output logic             xo_last,
    input  logic             xi_valid,
    output logic             xi_ready,
    input  logic [WIDTH-1:0] xi_data,
    input  logic             xi_last
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] TWO  = CW'(2);

    typedef struct packed {
        ctl_state_t    state;
        ctl_state_t    ret;
        logic          fill;
        logic [CW-1:0] cnt;
        logic [CW-1:0] tgt;
        logic [AW-1:0] msp;
        logic          away;
    } ctl_t;

    ctl_t st_q, st_d;

    slot_op_t         s_op;
    logic [WIDTH-1:0] s_wdata;
    logic [WIDTH-1:0] top0, top1, bottom;
    logic             mp_start, mp_we, mp_done;
    logic [AW-1:0]    mp_addr;
    logic [CW-1:0]    depth_fixed;
    logic             need_spill, need_fill;

    stk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (s_op),
        .wdata   (s_wdata),
        .widx    (st_q.cnt[IDXW-1:0]),
        .rd_idx  (IDXW'(st_q.cnt - 1'b1)),
        .top0    (top0),
        .top1    (top1),
        .rd_data (bottom)
    );

    stk_memport #(.AW(AW), .WIDTH(WIDTH)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (mp_start),
        .start_we    (mp_we),
        .start_addr  (mp_addr),
        .start_wdata (bottom),
        .done        (mp_done),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack)
    );

    always_comb begin
        if (cmd_depth == '0)     depth_fixed = ONE;
        else if (cmd_depth > FULL) depth_fixed = FULL;
        else                     depth_fixed = cmd_depth;
    end

    always_comb begin
        st_d       = st_q;
        s_op       = SO_NONE;
        s_wdata    = cmd_data;
        cmd_ready  = 1'b0;
        xo_valid   = 1'b0;
        xi_ready   = 1'b0;
        need_spill = 1'b0;
        need_fill  = 1'b0;
        mp_start   = 1'b0;
        mp_we      = 1'b0;
        mp_addr    = st_q.msp;
        st_d.away  = st_q.away && !at_home;

        unique case (st_q.state)
            ST_IDLE: if (cmd_valid) begin
                case (cmd_op)
                    OP_PUSH: if (st_q.cnt == FULL) need_spill = 1'b1;
                             else begin
                                 s_op      = SO_PUSH;
                                 st_d.cnt  = st_q.cnt + 1'b1;
                                 cmd_ready = 1'b1;
                             end
                    OP_POP:  if (st_q.cnt == '0) need_fill = 1'b1;
                             else begin
                                 s_op      = SO_POP;
                                 st_d.cnt  = st_q.cnt - 1'b1;
                                 cmd_ready = 1'b1;
                             end
                    OP_ADD:  if (st_q.cnt < TWO) need_fill = 1'b1;
                             else begin
                                 s_op      = SO_BIN;
                                 s_wdata   = top0 + top1;
                                 st_d.cnt  = st_q.cnt - 1'b1;
                                 cmd_ready = 1'b1;
                             end
                    OP_EXPORT: begin
                        st_d.tgt   = depth_fixed;
                        st_d.state = ST_XADJ;
                    end
                    OP_IMPORT: begin
                        st_d.cnt   = '0;
                        st_d.state = ST_XIN;
                    end
                    default: cmd_ready = 1'b1;
                endcase
            end
            ST_XADJ: begin
                if (st_q.cnt > st_q.tgt)      need_spill = 1'b1;
                else if (st_q.cnt < st_q.tgt) need_fill  = 1'b1;
                else                          st_d.state = ST_XOUT;
            end
            ST_MEM: if (mp_done) begin
                if (st_q.fill) begin
                    s_op     = SO_WR;
                    s_wdata  = mem_rdata;
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.msp = st_q.msp + 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    st_d.msp = st_q.msp - 1'b1;
                end
                st_d.state = st_q.ret;
            end
            ST_XOUT: begin
                xo_valid = (st_q.cnt != '0);
                if (xo_valid && xo_ready) begin
                    s_op     = SO_POP;
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == ONE) begin
                        cmd_ready  = 1'b1;
                        st_d.state = ST_IDLE;
                    end
                end
            end
            ST_XIN: begin
                xi_ready = 1'b1;
                if (xi_valid) begin
                    if (st_q.cnt != FULL) begin
                        s_op     = SO_WR;
                        s_wdata  = xi_data;
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                    if (xi_last) begin
                        cmd_ready  = 1'b1;
                        st_d.state = ST_IDLE;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase

        if (need_spill || need_fill) begin
            if (at_home) begin
                mp_start   = 1'b1;
                mp_we      = need_spill;
                mp_addr    = need_spill ? st_q.msp - 1'b1 : st_q.msp;
                st_d.fill  = need_fill;
                st_d.ret   = st_q.state;
                st_d.state = ST_MEM;
            end else begin
                st_d.away = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.ret   <= ST_IDLE;
            st_q.msp   <= SP_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tos_data  = top0;
    assign tos_count = st_q.cnt;
    assign ret_home  = st_q.away;
    assign xo_data   = top0;
    assign xo_last   = (st_q.cnt == ONE);

    // R10: a new memory request only starts from a cycle spent at home
    a_r10_no_req_away: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(at_home));

    // R3: every finished write-back lowers the memory stack pointer by one
    a_r3_spill_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we) |=> (st_q.msp == $past(st_q.msp) - 1'b1));

    // R4: every finished read-back raises the memory stack pointer by one
    a_r4_fill_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we) |=> (st_q.msp == $past(st_q.msp) + 1'b1));

    // R2: an accepted push grows the cached count by one
    a_r2_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_PUSH) |=>
        (tos_count == $past(tos_count) + 1'b1));

    // R6: no export word is offered while memory traffic is in flight
    a_r6_quiet_stream: assert property (@(posedge clk) disable iff (!rst_n)
        !(xo_valid && mem_req));

    // R9: the cached count never exceeds the window
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tos_count <= FULL);
endmodule

// File: tb/tb_stk_cache_top.sv
`timescale 1ns/1ps
module tb_stk_cache_top;
    import stk_pkg::*;

    localparam int            DEPTH   = 4;
    localparam int            WIDTH   = 16;
    localparam int            AW      = 8;
    localparam logic [AW-1:0] SP_BASE = 8'h40;
    localparam int            CW      = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [WIDTH-1:0] cmd_data = '0;
    logic [CW-1:0]    cmd_depth = '0;
    logic             cmd_ready;
    logic [WIDTH-1:0] tos_data;
    logic [CW-1:0]    tos_count;
    logic             at_home = 1'b1;
    logic             ret_home;
    logic             mem_req, mem_we;
    logic [AW-1:0]    mem_addr;
    logic [WIDTH-1:0] mem_wdata;
    logic             mem_ack = 1'b0;
    logic [WIDTH-1:0] mem_rdata = '0;
    logic             xo_valid, xo_last;
    logic             xo_ready = 1'b1;
    logic [WIDTH-1:0] xo_data;
    logic             xi_valid = 1'b0;
    logic             xi_ready;
    logic [WIDTH-1:0] xi_data = '0;
    logic             xi_last = 1'b0;

    stk_cache_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .SP_BASE(SP_BASE)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_depth(cmd_depth), .cmd_ready(cmd_ready),
        .tos_data(tos_data), .tos_count(tos_count), .at_home(at_home),
        .ret_home(ret_home), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .xo_valid(xo_valid), .xo_ready(xo_ready),
        .xo_data(xo_data), .xo_last(xo_last), .xi_valid(xi_valid),
        .xi_ready(xi_ready), .xi_data(xi_data), .xi_last(xi_last)
    );

    always #2 clk = ~clk;

    // stack memory model: acknowledges one cycle after a request appears
    logic [WIDTH-1:0] bmem [256];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 256; i++) bmem[i] <= 16'hA000 + WIDTH'(i);
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= bmem[mem_addr];
            if (mem_we) bmem[mem_addr] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // stream and memory activity monitor
    logic [WIDTH-1:0] xo_buf [8];
    logic             xo_lst [8];
    int xo_n = 0, late_mem = 0, away_req = 0;
    always @(negedge clk) if (rst_n) begin
        if (xo_valid && xo_ready) begin
            if (xo_n < 8) begin
                xo_buf[xo_n] = xo_data;
                xo_lst[xo_n] = xo_last;
            end
            xo_n++;
        end
        if (mem_req && xo_n > 0) late_mem++;
        if (mem_req && !at_home) away_req++;
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [WIDTH-1:0] d,
                          input logic [CW-1:0] dep);
        @(negedge clk);
        cmd_op = op; cmd_data = d; cmd_depth = dep; cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic do_import(input int n, input int base, input int step);
        @(negedge clk);
        cmd_op = OP_IMPORT; cmd_valid = 1'b1;
        @(posedge clk); #1;
        for (int k = 0; k < n; k++) begin
            xi_valid = 1'b1;
            xi_data  = WIDTH'(base + k * step);
            xi_last  = (k == n - 1);
            @(negedge clk);
            while (!xi_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        xi_valid = 1'b0; xi_last = 1'b0; cmd_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [2:0]       op;
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] tos;
        logic [CW-1:0]    cnt;
        logic [3:0]       req;
    } vec_t;

    // expected top word and count after each command, SP_BASE 0x40
    localparam vec_t VECS [19] = '{
        '{OP_PUSH, 16'd1,    16'd1,    3'd1, 4'd2},  // R2
        '{OP_PUSH, 16'd2,    16'd2,    3'd2, 4'd2},
        '{OP_PUSH, 16'd3,    16'd3,    3'd3, 4'd2},
        '{OP_PUSH, 16'd4,    16'd4,    3'd4, 4'd2},
        '{OP_PUSH, 16'd5,    16'd5,    3'd4, 4'd3},  // R3 word 1 -> 0x3F
        '{OP_PUSH, 16'd6,    16'd6,    3'd4, 4'd3},  // R3 word 2 -> 0x3E
        '{OP_ADD,  16'd0,    16'd11,   3'd3, 4'd2},
        '{OP_ADD,  16'd0,    16'd15,   3'd2, 4'd2},
        '{OP_ADD,  16'd0,    16'd18,   3'd1, 4'd2},
        '{OP_ADD,  16'd0,    16'd20,   3'd1, 4'd4},  // R4 reads 2 from 0x3E
        '{OP_POP,  16'd0,    16'd0,    3'd0, 4'd2},
        '{OP_POP,  16'd0,    16'd0,    3'd0, 4'd4},  // R4 reads 1 from 0x3F
        '{OP_PUSH, 16'd7,    16'd7,    3'd1, 4'd2},
        '{OP_PUSH, 16'hFFFF, 16'hFFFF, 3'd2, 4'd2},
        '{OP_PUSH, 16'd2,    16'd2,    3'd3, 4'd2},
        '{OP_ADD,  16'd0,    16'd1,    3'd2, 4'd2},  // R2 wrap
        '{OP_ADD,  16'd0,    16'd8,    3'd1, 4'd2},
        '{OP_POP,  16'd0,    16'd0,    3'd0, 4'd2},
        '{3'd5,    16'd0,    16'd0,    3'd0, 4'd11}  // R11 no effect
    };

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 count", 32'(tos_count), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 xo_valid", 32'(xo_valid), 0);
        chk("R1 xi_ready", 32'(xi_ready), 0);
        chk("R1 ret_home", 32'(ret_home), 0);
        chk("R1 cmd_ready", 32'(cmd_ready), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 19; v++) begin
            do_cmd(VECS[v].op, VECS[v].data, '0);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d count", VECS[v].req, v), 32'(tos_count), 32'(VECS[v].cnt));
            if (VECS[v].cnt != '0)
                chk($sformatf("R%0d vec%0d top", VECS[v].req, v), 32'(tos_data), 32'(VECS[v].tos));
        end
        // R3 spilled words sit below SP_BASE
        chk("R3 mem 0x3F", 32'(bmem[8'h3F]), 1);
        chk("R3 mem 0x3E", 32'(bmem[8'h3E]), 2);

        // R6 export of depth 2 from 50,40,30,20 (10 already in 0x3F)
        for (int k = 1; k <= 5; k++) do_cmd(OP_PUSH, WIDTH'(k * 10), '0);
        xo_n = 0; late_mem = 0;
        do_cmd(OP_EXPORT, '0, 3'd2);
        @(negedge clk);
        chk("R6 mem 0x3E", 32'(bmem[8'h3E]), 20);
        chk("R6 mem 0x3D", 32'(bmem[8'h3D]), 30);
        chk("R6 no write after stream", 32'(late_mem), 0);
        chk("R8 words", 32'(xo_n), 2);
        chk("R8 word0", 32'(xo_buf[0]), 50);
        chk("R8 word1", 32'(xo_buf[1]), 40);
        chk("R8 last flags", {30'd0, xo_lst[0], xo_lst[1]}, 1);
        chk("R8 empty", 32'(tos_count), 0);

        // R7 export of depth 3 from an empty cache
        xo_n = 0;
        do_cmd(OP_EXPORT, '0, 3'd3);
        @(negedge clk);
        chk("R7 words", 32'(xo_n), 3);
        chk("R7 word0", 32'(xo_buf[0]), 30);
        chk("R7 word1", 32'(xo_buf[1]), 20);
        chk("R7 word2", 32'(xo_buf[2]), 10);
        chk("R7 last", 32'(xo_lst[2]), 1);

        // R8 depth 0 counts as 1
        do_cmd(OP_PUSH, 16'd9, '0);
        xo_n = 0;
        do_cmd(OP_EXPORT, '0, 3'd0);
        @(negedge clk);
        chk("R8 zero words", 32'(xo_n), 1);
        chk("R8 zero word", 32'(xo_buf[0]), 9);
        chk("R8 zero last", 32'(xo_lst[0]), 1);

        // R8 depth 7 clamps to 4, fills from 0x40..0x43
        xo_n = 0;
        do_cmd(OP_EXPORT, '0, 3'd7);
        @(negedge clk);
        chk("R8 clamp words", 32'(xo_n), 4);
        chk("R8 clamp word0", 32'(xo_buf[0]), 32'hA040);
        chk("R8 clamp word3", 32'(xo_buf[3]), 32'hA043);

        // R9 import order
        do_import(3, 100, 100);
        @(negedge clk);
        chk("R9 count", 32'(tos_count), 3);
        chk("R9 top", 32'(tos_data), 100);
        do_cmd(OP_ADD, '0, '0);
        @(negedge clk);
        chk("R9 sum of first two", 32'(tos_data), 300);
        do_cmd(OP_POP, '0, '0);
        @(negedge clk);
        chk("R9 third word", 32'(tos_data), 300);
        chk("R9 count after pop", 32'(tos_count), 1);

        // R9 words past the window are dropped
        do_import(6, 1, 1);
        @(negedge clk);
        chk("R9 overfull count", 32'(tos_count), 4);
        xo_n = 0;
        do_cmd(OP_EXPORT, '0, 3'd4);
        @(negedge clk);
        chk("R9 kept words", 32'(xo_n), 4);
        chk("R9 kept deepest", 32'(xo_buf[3]), 4);

        // R10 away from home
        do_import(4, 11, 1);
        away_req = 0;
        at_home = 1'b0;
        @(negedge clk);
        cmd_op = OP_PUSH; cmd_data = 16'd99; cmd_valid = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 ret_home", 32'(ret_home), 1);
        chk("R10 no request", 32'(away_req), 0);
        chk("R10 not ready", 32'(cmd_ready), 0);
        chk("R10 count held", 32'(tos_count), 4);
        at_home = 1'b1;
        #1;
        while (!cmd_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R10 flag cleared", 32'(ret_home), 0);
        chk("R10 top", 32'(tos_data), 99);
        chk("R5 spill went to 0x43", 32'(bmem[8'h43]), 14);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule